// File: doc/BRIEF.md
# Resource-Block Subcarrier Mapper

This block sits in front of an inverse transform in a multi-carrier transmitter. It accepts a stream of complex constellation points, one resource block of twelve points at a time. For each block it produces a 64-entry frequency-domain array. The twelve points land in the middle of the array, and every other position comes out as zero. Each array is presented in bin order, from the lowest bin to the highest, so the transform that follows can consume it directly.

Two storage banks alternate roles. While one bank collects the next block, the other is read out in full. Only the twelve useful points are written. The zero positions are generated during readout by comparing the bin index, so the inverse transform sees a full 64-sample array without 52 wasted write cycles.

Both sides use valid/ready handshakes. A beat transfers on a rising clock edge only when valid and ready are both high.
- When both banks hold unread blocks, the input side stops accepting data.
- The output side may stall at any time. A stalled output beat stays unchanged until it is taken.

Top module: `sc_bin_mapper`

## Requirements
- R1: After reset, m_valid is low and s_ready is high (both banks empty).
- R2: Each output array is exactly 64 beats, bins 0 to 63 in increasing order, with m_last high on bin 63 only.
- R3: The k-th accepted symbol of a block (k = 0..11) appears at output bin 26+k of that block's array.
- R4: Output bins 0..25 and 38..63 carry zero in both real and imaginary parts.
- R5: Up to 24 symbols (two blocks) are accepted while no output is taken; s_ready is low while both banks are full, and it returns high once a whole 64-beat array has been emitted.
- R6: While m_valid is high and m_ready is low, m_valid, m_re, m_im and m_last hold their values.
- R7: m_valid rises on the first clock edge after the twelfth symbol of a block is accepted into an empty output path.
- R8: Real and imaginary parts are 16-bit signed Q5.11 words, passed unchanged bit for bit, including the extremes 0x7FFF and 0x8000.
- R9: Arrays leave in the order their blocks were filled. Writing one bank never disturbs the array being read from the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_valid | input | 1 | Input symbol valid |
| s_ready | output | 1 | Mapper can accept a symbol |
| s_re | input | 16 | Input real part, Q5.11 |
| s_im | input | 16 | Input imaginary part, Q5.11 |
| m_valid | output | 1 | Output bin valid |
| m_ready | input | 1 | Downstream accepts the bin |
| m_re | output | 16 | Output real part, Q5.11 |
| m_im | output | 16 | Output imaginary part, Q5.11 |
| m_last | output | 1 | High on bin 63 of an array |

## Verification
A directed opening uses extreme-value symbols with the output held off. This separates the fill latency, the point where both banks are full, and the hold behaviour during a stall inside the central bins. A long run then uses random data with random valid and ready duty cycles on both sides. That run overlaps filling and draining across bank swaps, which exposes bank-ownership or ordering errors that a steady stream would hide. Every beat is compared against arrays rebuilt from the accepted symbols. This checks zero bins, central placement and last-beat marking together.

// File: rtl/smap_pkg.sv
package smap_pkg;
  localparam int CPLX_W = 16;

  typedef struct packed {
    logic signed [CPLX_W-1:0] re;
    logic signed [CPLX_W-1:0] im;
  } cplx_t;

  localparam int CPLX_BITS = 2 * CPLX_W;
endpackage

// File: rtl/smap_bank.sv
module smap_bank #(
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter int W     = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/smap_writer.sv
module smap_writer #(
  parameter int NSYM = 12,
  parameter int BIN0 = 26,
  parameter int AW   = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          s_valid,
  input  logic [1:0]    bank_full,
  output logic          s_ready,
  output logic [1:0]    bank_we,
  output logic [AW-1:0] waddr,
  output logic          fill_done,
  output logic          wr_sel
);
  localparam int CW = (NSYM > 1) ? $clog2(NSYM) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(NSYM - 1);

  logic [CW-1:0] cnt;
  logic          take;

  assign s_ready   = !bank_full[wr_sel];
  assign take      = s_valid && s_ready;
  assign bank_we   = take ? (wr_sel ? 2'b10 : 2'b01) : 2'b00;
  assign waddr     = AW'(BIN0) + AW'(cnt);
  assign fill_done = take && (cnt == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      wr_sel <= 1'b0;
    end else if (take) begin
      if (cnt == LAST_IDX) begin
        cnt    <= '0;
        wr_sel <= !wr_sel;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R3
  fill_index_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST_IDX);
endmodule

// File: rtl/smap_reader.sv
module smap_reader #(
  parameter int NBINS = 64,
  parameter int NSYM  = 12,
  parameter int BIN0  = 26,
  parameter int AW    = 6,
  parameter int W     = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    bank_full,
  input  logic [W-1:0]  bank_rdata,
  input  logic          m_ready,
  output logic [AW-1:0] raddr,
  output logic          rd_sel,
  output logic          m_valid,
  output logic [W-1:0]  m_data,
  output logic          m_last,
  output logic          drained
);
  localparam logic [AW-1:0] LO_BIN  = AW'(BIN0);
  localparam logic [AW-1:0] HI_BIN  = AW'(BIN0 + NSYM - 1);
  localparam logic [AW-1:0] END_BIN = AW'(NBINS - 1);

  logic [AW-1:0] bin;
  logic          in_band;
  logic          fire;

  assign raddr   = bin;
  assign in_band = (bin >= LO_BIN) && (bin <= HI_BIN);
  assign m_valid = bank_full[rd_sel];
  assign m_data  = in_band ? bank_rdata : '0;
  assign m_last  = (bin == END_BIN);
  assign fire    = m_valid && m_ready;
  assign drained = fire && m_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      bin    <= '0;
      rd_sel <= 1'b0;
    end else if (fire) begin
      if (m_last) begin
        bin    <= '0;
        rd_sel <= !rd_sel;
      end else begin
        bin <= bin + 1'b1;
      end
    end
  end

  // R6
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));
endmodule

// File: rtl/sc_bin_mapper.sv
module sc_bin_mapper #(
  parameter int NBINS = 64,
  parameter int NSYM  = 12
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        s_valid,
  output logic        s_ready,
  input  logic [15:0] s_re,
  input  logic [15:0] s_im,
  output logic        m_valid,
  input  logic        m_ready,
  output logic [15:0] m_re,
  output logic [15:0] m_im,
  output logic        m_last
);
  import smap_pkg::*;

  localparam int AW   = $clog2(NBINS);
  localparam int BIN0 = (NBINS - NSYM) / 2;
  localparam int W    = CPLX_BITS;

  logic [1:0]    bank_full;
  logic [1:0]    bank_we;
  logic [AW-1:0] waddr;
  logic [AW-1:0] raddr;
  logic          fill_done;
  logic          drained;
  logic          wr_sel;
  logic          rd_sel;
  logic [W-1:0]  rdata [2];
  logic [W-1:0]  sel_rdata;
  cplx_t         in_sym;
  cplx_t         out_sym;

  assign in_sym.re = s_re;
  assign in_sym.im = s_im;

  smap_writer #(.NSYM(NSYM), .BIN0(BIN0), .AW(AW)) u_writer (
    .clk(clk), .rst(rst), .s_valid(s_valid), .bank_full(bank_full),
    .s_ready(s_ready), .bank_we(bank_we), .waddr(waddr),
    .fill_done(fill_done), .wr_sel(wr_sel)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    smap_bank #(.DEPTH(NBINS), .AW(AW), .W(W)) u_bank (
      .clk(clk), .we(bank_we[b]), .waddr(waddr), .wdata(in_sym),
      .raddr(raddr), .rdata(rdata[b])
    );

    always_ff @(posedge clk) begin
      if (rst)
        bank_full[b] <= 1'b0;
      else if (fill_done && (wr_sel == 1'(b)))
        bank_full[b] <= 1'b1;
      else if (drained && (rd_sel == 1'(b)))
        bank_full[b] <= 1'b0;
    end
  end

  assign sel_rdata = rd_sel ? rdata[1] : rdata[0];

  smap_reader #(.NBINS(NBINS), .NSYM(NSYM), .BIN0(BIN0), .AW(AW), .W(W)) u_reader (
    .clk(clk), .rst(rst), .bank_full(bank_full), .bank_rdata(sel_rdata),
    .m_ready(m_ready), .raddr(raddr), .rd_sel(rd_sel), .m_valid(m_valid),
    .m_data(out_sym), .m_last(m_last), .drained(drained)
  );

  assign m_re = out_sym.re;
  assign m_im = out_sym.im;

  // Beat counter kept only for checking the array framing.
  logic [AW-1:0] beat_cnt;
  always_ff @(posedge clk) begin
    if (rst) beat_cnt <= '0;
    else if (m_valid && m_ready) beat_cnt <= beat_cnt + 1'b1;
  end

  // R2
  last_position_chk: assert property (@(posedge clk) disable iff (rst)
    m_valid |-> (m_last == (beat_cnt == AW'(NBINS - 1))));

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!m_valid && s_ready));

  // R5
  both_full_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (bank_full == 2'b11) |-> !s_ready);

  // R9
  single_bank_write_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bank_we) && ((bank_we & bank_full) == 2'b00));
endmodule

// File: tb/test_sc_bin_mapper.sv
module test_sc_bin_mapper;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [15:0] s_re = '0;
  logic [15:0] s_im = '0;
  logic        m_valid;
  logic        m_ready = 1'b0;
  logic [15:0] m_re;
  logic [15:0] m_im;
  logic        m_last;

  int total = 0;
  int failed = 0;
  bit finished = 0;
  logic [31:0] in_q[$];
  int out_bin = 0;
  int out_arr = 0;

  always #10 clk = ~clk;

  sc_bin_mapper i_sc_bin_mapper (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready),
    .s_re(s_re), .s_im(s_im), .m_valid(m_valid), .m_ready(m_ready),
    .m_re(m_re), .m_im(m_im), .m_last(m_last)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expect_bin(input int arr, input int b);
    if (b >= 26 && b <= 37) return in_q[arr * 12 + b - 26];
    return 32'h0;
  endfunction

  task automatic cycle(input logic v, input logic [31:0] d, input logic r);
    @(negedge clk);
    s_valid = v; {s_re, s_im} = d; m_ready = r;
    #1;
    if (s_valid && s_ready) in_q.push_back(d);
    if (m_valid && m_ready) begin
      logic [31:0] e;
      e = expect_bin(out_arr, out_bin);
      if (out_bin >= 26 && out_bin <= 37)
        check({m_re, m_im} == e, "R3 central bin / R9 order", {32'h0, m_re, m_im}, {32'h0, e});
      else
        check({m_re, m_im} == 32'h0, "R4 zero bin", {32'h0, m_re, m_im}, 64'h0);
      check(m_last == (out_bin == 63), "R2 last flag", {63'h0, m_last}, {63'h0, out_bin == 63});
      if (out_bin == 63) begin out_bin = 0; out_arr++; end
      else out_bin++;
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", total, failed);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] hold_re, hold_im;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    // R1
    check(!m_valid, "R1 valid after reset", {63'h0, m_valid}, 64'h0);
    check(s_ready, "R1 ready after reset", {63'h0, s_ready}, 64'h1);

    // Fill first block with output stalled; extremes first (R8)
    cycle(1'b1, {16'h7FFF, 16'h8000}, 1'b0);
    for (int k = 1; k < 12; k++) cycle(1'b1, {16'(k * 37), 16'(-k * 91)}, 1'b0);
    check(!m_valid, "R7 no valid before 12th accept", {63'h0, m_valid}, 64'h0);
    cycle(1'b0, 32'h0, 1'b0);
    check(m_valid, "R7 valid after 12th accept", {63'h0, m_valid}, 64'h1);

    // Second block fills the other bank (R5)
    for (int k = 0; k < 12; k++) begin
      cycle(1'b1, {16'h8000 + 16'(k), 16'h7FFF - 16'(k)}, 1'b0);
      check(in_q.size() == 13 + k, "R5 second block accepted", 64'(in_q.size()), 64'(13 + k));
    end
    cycle(1'b1, 32'hDEAD_BEEF, 1'b0);
    check(!s_ready && in_q.size() == 24, "R5 ready low when both full", {63'h0, s_ready}, 64'h0);

    // Advance into the central bins, then stall (R6, R8)
    for (int k = 0; k < 26; k++) cycle(1'b0, 32'h0, 1'b1);
    cycle(1'b0, 32'h0, 1'b0);
    hold_re = m_re; hold_im = m_im;
    check(m_re == 16'h7FFF && m_im == 16'h8000, "R8 extreme values", {32'h0, m_re, m_im}, 64'h7FFF8000);
    for (int k = 0; k < 3; k++) begin
      cycle(1'b1, 32'h1234_5678, 1'b0);
      check(m_valid && m_re == hold_re && m_im == hold_im, "R6 hold under stall",
            {31'h0, m_valid, m_re, m_im}, {31'h0, 1'b1, hold_re, hold_im});
      check(!s_ready, "R5 still blocked", {63'h0, s_ready}, 64'h0);
    end
    // Drain first array; ready returns (R5)
    while (out_arr == 0) cycle(1'b0, 32'h0, 1'b1);
    cycle(1'b0, 32'h0, 1'b0);
    check(s_ready, "R5 ready after array drained", {63'h0, s_ready}, 64'h1);

    // Random overlapping traffic (R3, R4, R9)
    for (int c = 0; c < 6000; c++) begin
      logic v, r;
      v = ($urandom % 100) < 60;
      r = ($urandom % 100) < 85;
      cycle(v, $urandom, r);
    end
    for (int c = 0; c < 3000 && out_arr < int'(in_q.size() / 12); c++)
      cycle(1'b0, 32'h0, 1'b1);
    // R9
    check(out_arr == int'(in_q.size() / 12), "R9 all filled arrays emitted in order",
          64'(out_arr), 64'(in_q.size() / 12));
    finish_run();
  end
endmodule